// File: doc/BRIEF.md
# Reset Cause and Request Register

This block holds one 32-bit register that records why the system was last reset and lets software ask for a new reset. Five bits at the top of the word are live. Three are cause flags: the power-on cause, the button cold-reset cause and the button warm-reset cause. Software clears them by writing ones. Two are software request flags, one cold and one warm. A write can only set them. Any write that sets a request flag also emits a one-cycle request pulse towards the system reset sequencer.

A small saturating counter tracks how many system resets have gone by since the last power-on. When a system reset arrives and the counter is zero, the register is reloaded so that only the power-on cause is set. Later resets leave the register alone. A software cold request sets the counter back to zero, so the reset it triggers is treated as a fresh power-on. Two strobe inputs from the button logic set the two button cause flags.

The register bus is a plain single-cycle interface. A write takes effect on the clock edge where `bus_valid` and `bus_write` are high. Read data is a combinational function of the address. There is no back-pressure: the register is always ready. No data stream passes through the block, so every pin is a plain control or status signal.

Top module: `rcs_reset_ctl`

## Requirements
- R1: After power-up (`por_n` low), the register reads 0x00000000 and `sys_reset_req_o` is low. Bits 26:0 always read as zero.
- R2: Write data bits 26:0 have no effect. At bits 31 (power-on cause), 28 (button cold cause) and 27 (button warm cause), a written one clears the bit and a written zero leaves it unchanged.
- R3: At bits 30 (software cold request) and 29 (software warm request), a written one sets the bit and a written zero leaves it unchanged. Once set, these bits are cleared only by a system reset that reloads the register, or by power-up.
- R4: The register is decoded at byte address WIN_BASE+4 only, with address bits 1:0 zero. Writes to WIN_BASE+0 (the lower word of the 8-byte window) and to any other address change nothing, and those addresses read as zero.
- R5: An accepted write with bit 30 set drives `sys_reset_req_o` high for exactly the next cycle and zeroes the reset counter. The next `sys_reset_i` then reloads the register to 0x80000000.
- R6: An accepted write with bit 29 set and bit 30 clear drives the same one-cycle request but leaves the counter unchanged.
- R7: On a `sys_reset_i` cycle with the counter at zero, the register becomes 0x80000000. With a nonzero counter, it keeps its value. Either way the counter then increments.
- R8: The counter starts at zero on power-up and saturates at 2^CNT_W-1. A run of system resets therefore never reloads the register a second time.
- R9: A high `btn_cold_i` sets bit 28 and a high `btn_warm_i` sets bit 27 on that clock edge. A strobe wins over a write-one-to-clear of the same bit in the same cycle.
- R10: In a cycle where `sys_reset_i` is high, bus writes and button strobes are ignored and no request pulse follows.
- R11: Reads have no side effects. Reading the register twice in a row gives the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_reset_i | input | 1 | One-cycle system reset event from the sequencer |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| btn_cold_i | input | 1 | Button cold-reset cause strobe |
| btn_warm_i | input | 1 | Button warm-reset cause strobe |
| sys_reset_req_o | output | 1 | One-cycle reset request to the sequencer |

## Verification
The assertions assume that `sys_reset_i` arrives as a pulse synchronous to `clk`, and that bus and strobe inputs are synchronous and free of X after power-up. They also assume that a request pulse follows only from a bus write seen on the previous edge. The bench changes every input on the falling clock edge and holds it for one full cycle. It never lets `sys_reset_i` overlap the cycle in which a request pulse is expected, except in the R10 case, which is built to test exactly that overlap.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned FIELD_LO  = 27;
  localparam int unsigned FIELD_N   = REG_W - FIELD_LO;

  localparam int unsigned B_POWER     = 31;
  localparam int unsigned B_SW_COLD   = 30;
  localparam int unsigned B_SW_WARM   = 29;
  localparam int unsigned B_BTN_COLD  = 28;
  localparam int unsigned B_BTN_WARM  = 27;

  localparam logic [REG_W-1:0] POWER_ONLY = 32'h8000_0000;

  typedef enum logic {FK_CLEAR_ON_ONE, FK_SET_ON_ONE} field_kind_e;

  function automatic field_kind_e field_kind(int unsigned bitpos);
    return (bitpos == B_SW_COLD || bitpos == B_SW_WARM) ? FK_SET_ON_ONE
                                                        : FK_CLEAR_ON_ONE;
  endfunction
endpackage

// File: rtl/rcs_decode.sv
module rcs_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF020
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              sys_reset_i,
  output logic              sel_upper,
  output logic              wr_fire
);
  localparam logic [ADDR_W-1:0] BASE = WIN_BASE;

  always_comb begin
    sel_upper = (bus_addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]) &&
                (bus_addr[2:0] == 3'b100);
    wr_fire   = bus_valid && bus_write && sel_upper && !sys_reset_i;
  end
endmodule

// File: rtl/rcs_epoch_counter.sv
module rcs_epoch_counter #(
  parameter int unsigned CNT_W = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic clear,
  input  logic inc,
  output logic is_zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                        cnt_q <= '0;
    else if (clear)                    cnt_q <= '0;
    else if (inc && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign is_zero = (cnt_q == '0);

  assert_saturate_R8: assert property (@(posedge clk) disable iff (!por_n)
    (cnt_q == CNT_MAX && !clear) |=> (cnt_q == CNT_MAX));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!por_n)
    clear |=> is_zero);
endmodule

// File: rtl/rcs_cause_bits.sv
module rcs_cause_bits
  import rcs_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               load_first,
  input  logic               hold,
  input  logic               wr_en,
  input  logic [FIELD_N-1:0] wfield,
  input  logic [FIELD_N-1:0] strobe,
  output logic [REG_W-1:0]   reg_q
);
  logic [FIELD_N-1:0] fld_q;
  logic [FIELD_N-1:0] fld_nxt;

  for (genvar i = 0; i < FIELD_N; i++) begin : g_fld
    localparam int unsigned BPOS = FIELD_LO + i;
    if (field_kind(BPOS) == FK_SET_ON_ONE) begin : g_set
      assign fld_nxt[i] = fld_q[i] | (wr_en & wfield[i]);
    end else begin : g_clr
      assign fld_nxt[i] = (fld_q[i] & ~(wr_en & wfield[i])) | strobe[i];
    end

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          fld_q[i] <= 1'b0;
      else if (load_first) fld_q[i] <= POWER_ONLY[BPOS];
      else if (!hold)      fld_q[i] <= fld_nxt[i];
    end
  end

  assign reg_q = {fld_q, {FIELD_LO{1'b0}}};

  assert_first_load_R7: assert property (@(posedge clk) disable iff (!por_n)
    load_first |=> (reg_q == POWER_ONLY));

  assert_later_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
    (hold && !load_first) |=> $stable(reg_q));

  assert_sticky_cold_R3: assert property (@(posedge clk) disable iff (!por_n)
    (!hold && reg_q[B_SW_COLD]) |=> reg_q[B_SW_COLD]);

  assert_sticky_warm_R3: assert property (@(posedge clk) disable iff (!por_n)
    (!hold && reg_q[B_SW_WARM]) |=> reg_q[B_SW_WARM]);

  assert_btn_set_R9: assert property (@(posedge clk) disable iff (!por_n)
    (!hold && strobe[B_BTN_COLD-FIELD_LO]) |=> reg_q[B_BTN_COLD]);
endmodule

// File: rtl/rcs_req_pulse.sv
module rcs_req_pulse (
  input  logic clk,
  input  logic por_n,
  input  logic fire,
  output logic req_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) req_q <= 1'b0;
    else        req_q <= fire;
  end
endmodule

// File: rtl/rcs_reset_ctl.sv
module rcs_reset_ctl
  import rcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF020,
  parameter int unsigned CNT_W = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_reset_i,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              btn_cold_i,
  input  logic              btn_warm_i,
  output logic              sys_reset_req_o
);
  logic               sel_upper;
  logic               wr_fire;
  logic               cnt_zero;
  logic [REG_W-1:0]   reg_q;
  logic [FIELD_N-1:0] wfield;
  logic [FIELD_N-1:0] strobe;
  logic               req_fire;
  logic               cnt_clear;

  assign wfield = bus_wdata[REG_W-1:FIELD_LO];

  always_comb begin
    strobe = '0;
    strobe[B_BTN_COLD-FIELD_LO] = btn_cold_i;
    strobe[B_BTN_WARM-FIELD_LO] = btn_warm_i;
  end

  assign req_fire  = wr_fire && (bus_wdata[B_SW_COLD] || bus_wdata[B_SW_WARM]);
  assign cnt_clear = wr_fire && bus_wdata[B_SW_COLD];

  rcs_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_decode (
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .sys_reset_i (sys_reset_i),
    .sel_upper   (sel_upper),
    .wr_fire     (wr_fire)
  );

  rcs_epoch_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .por_n   (por_n),
    .clear   (cnt_clear),
    .inc     (sys_reset_i),
    .is_zero (cnt_zero)
  );

  rcs_cause_bits u_bits (
    .clk        (clk),
    .por_n      (por_n),
    .load_first (sys_reset_i && cnt_zero),
    .hold       (sys_reset_i),
    .wr_en      (wr_fire),
    .wfield     (wfield),
    .strobe     (strobe),
    .reg_q      (reg_q)
  );

  rcs_req_pulse u_req (
    .clk   (clk),
    .por_n (por_n),
    .fire  (req_fire),
    .req_q (sys_reset_req_o)
  );

  assign bus_rdata = sel_upper ? reg_q : '0;

  assert_req_source_R5: assert property (@(posedge clk) disable iff (!por_n)
    sys_reset_req_o |-> $past(bus_valid && bus_write && sel_upper && !sys_reset_i &&
                              (bus_wdata[B_SW_COLD] || bus_wdata[B_SW_WARM])));

  assert_no_req_after_reset_R10: assert property (@(posedge clk) disable iff (!por_n)
    sys_reset_i |=> !sys_reset_req_o);

  assert_lower_word_zero_R4: assert property (@(posedge clk) disable iff (!por_n)
    !bus_addr[2] |-> (bus_rdata == '0));

  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!por_n)
    bus_rdata[FIELD_LO-1:0] == '0);
endmodule

// File: tb/tb_rcs_reset_ctl.sv
module tb_rcs_reset_ctl;
  localparam logic [15:0] A_UP  = 16'hF024;
  localparam logic [15:0] A_LO  = 16'hF020;
  localparam logic [15:0] A_OUT = 16'h1234;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_reset_i = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [15:0] bus_addr = A_UP;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        btn_cold_i = 1'b0;
  logic        btn_warm_i = 1'b0;
  logic        sys_reset_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  rcs_reset_ctl dut (
    .clk(clk), .por_n(por_n), .sys_reset_i(sys_reset_i),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .btn_cold_i(btn_cold_i), .btn_warm_i(btn_warm_i),
    .sys_reset_req_o(sys_reset_req_o)
  );

  // {upper_word, wdata, expected readback, expected request}
  localparam int NV = 8;
  localparam logic [65:0] VEC [NV] = '{
    {1'b1, 32'h0000_0000, 32'h8000_0000, 1'b0},  // R2 zero write keeps
    {1'b1, 32'h07FF_FFFF, 32'h8000_0000, 1'b0},  // R2 unused bits
    {1'b1, 32'h2000_0000, 32'hA000_0000, 1'b1},  // R3/R6 warm request
    {1'b1, 32'h0000_0000, 32'hA000_0000, 1'b0},  // R3 sticky
    {1'b1, 32'h8000_0000, 32'h2000_0000, 1'b0},  // R2 clear power cause
    {1'b1, 32'h4000_0000, 32'h6000_0000, 1'b1},  // R5 cold request
    {1'b1, 32'hE000_0000, 32'h6000_0000, 1'b1},  // R2/R3 mixed
    {1'b0, 32'h9800_0000, 32'h6000_0000, 1'b0}   // R4 lower word ignored
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic v, logic w, logic [15:0] a, logic [31:0] d,
                      logic bc, logic bw, logic sr, output logic req);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    btn_cold_i = bc; btn_warm_i = bw; sys_reset_i = sr;
    @(negedge clk);
    req = sys_reset_req_o;
    bus_valid = 0; bus_write = 0; bus_wdata = '0;
    btn_cold_i = 0; btn_warm_i = 0; sys_reset_i = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    bus_addr = a;
    #1ns;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] d2;
    logic        rq;

    repeat (3) @(negedge clk);
    por_n = 1'b1;
    rd(A_UP, d);
    check("R1 reset value", d, 32'h0);
    check("R1 no request", {31'b0, sys_reset_req_o}, 32'h0);

    step(0, 0, A_UP, 0, 0, 0, 1, rq);
    rd(A_UP, d);
    check("R7 first reset loads power cause", d, 32'h8000_0000);

    for (int i = 0; i < NV; i++) begin
      step(1, 1, VEC[i][65] ? A_UP : A_LO, VEC[i][64:33], 0, 0, 0, rq);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d request", i), {31'b0, rq}, {31'b0, VEC[i][0]});
      rd(A_UP, d);
      check($sformatf("R2/R3/R4 vector %0d readback", i), d, VEC[i][32:1]);
    end
    @(negedge clk);
    check("R5 pulse lasts one cycle", {31'b0, sys_reset_req_o}, 32'h0);

    // R5: counter cleared by cold request, next reset reloads
    step(0, 0, A_UP, 0, 0, 0, 1, rq);
    rd(A_UP, d);
    check("R5 reload after cold request", d, 32'h8000_0000);
    step(1, 1, A_UP, 32'h8000_0000, 0, 0, 0, rq);
    step(0, 0, A_UP, 0, 0, 0, 1, rq);
    rd(A_UP, d);
    check("R7 later reset keeps value", d, 32'h0);

    // R6: warm request keeps counter
    step(1, 1, A_UP, 32'h2000_0000, 0, 0, 0, rq);
    check("R6 warm request pulse", {31'b0, rq}, 32'h1);
    step(0, 0, A_UP, 0, 0, 0, 1, rq);
    rd(A_UP, d);
    check("R6 no reload after warm request", d, 32'h2000_0000);

    // R8: counter saturates, never reloads
    for (int k = 0; k < 5; k++) begin
      step(0, 0, A_UP, 0, 0, 0, 1, rq);
      rd(A_UP, d);
      check($sformatf("R8 saturate reset %0d", k), d, 32'h2000_0000);
    end

    // R9: button strobes
    step(0, 0, A_UP, 0, 1, 0, 0, rq);
    rd(A_UP, d);
    check("R9 button cold sets bit 28", d, 32'h3000_0000);
    step(0, 0, A_UP, 0, 0, 1, 0, rq);
    rd(A_UP, d);
    check("R9 button warm sets bit 27", d, 32'h3800_0000);
    step(1, 1, A_UP, 32'h1800_0000, 0, 0, 0, rq);
    rd(A_UP, d);
    check("R2 clear button causes", d, 32'h2000_0000);
    step(1, 1, A_UP, 32'h1000_0000, 1, 0, 0, rq);
    rd(A_UP, d);
    check("R9 strobe wins over clear", d, 32'h3000_0000);

    // R10: write and strobe during system reset are ignored
    step(1, 1, A_UP, 32'h5000_0000, 0, 1, 1, rq);
    rd(A_UP, d);
    check("R10 write and strobe ignored", d, 32'h3000_0000);
    check("R10 no request", {31'b0, sys_reset_req_o}, 32'h0);

    // R4: other addresses
    step(1, 1, A_OUT, 32'h1000_0000, 0, 0, 0, rq);
    rd(A_UP, d);
    check("R4 outside write ignored", d, 32'h3000_0000);
    rd(A_OUT, d);
    check("R4 outside reads zero", d, 32'h0);
    rd(A_LO, d);
    check("R4 lower word reads zero", d, 32'h0);

    // R11: reads without side effects
    @(negedge clk);
    bus_valid = 1; bus_write = 0;
    rd(A_UP, d);
    @(negedge clk);
    rd(A_UP, d2);
    bus_valid = 0;
    check("R11 repeat read stable", d2, d);
    check("R11 value kept", d2, 32'h3000_0000);

    // R1: power-up again clears everything and counter
    @(negedge clk);
    por_n = 0;
    @(negedge clk);
    por_n = 1;
    rd(A_UP, d);
    check("R1 power-up clears", d, 32'h0);
    step(0, 0, A_UP, 0, 0, 0, 1, rq);
    rd(A_UP, d);
    check("R8 counter zero after power-up", d, 32'h8000_0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule